// File: doc/BRIEF.md
# Dual Auto-Reload Down Timer

This block holds two down-counting timer channels, A and B, that share one control register and a simple register bus. Each channel has a count buffer and a compare buffer that software writes at leisure. The buffers reach the live counter only in two ways. One is an explicit load strobe held in the control register. The other is an automatic reload when the counter passes through zero while repeat mode is on. Both channels step on a tick enable that comes from a divide-by-two of the bus clock.

A channel that reaches zero emits a one-cycle interrupt pulse and sets a sticky status bit, which is cleared by writing a 1 to it. In repeat mode the channel then reloads and keeps going. In single mode it stops: its run bit clears and the count stays at zero. Because the counter visits zero before it reloads, a buffer value of N gives a period of N+1 ticks. Software therefore programs one less than the period it wants.

The live count of channel B can be read on the bus. Loaded with all ones in repeat mode, channel B serves as a free-running time base whose inverted read value increases steadily.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every readable register reads 0 and both interrupt outputs are low.
- R2: With repeat mode on and count buffer N, the channel's interrupt pulses every 2*(N+1) clock cycles: one tick every two clocks and N+1 ticks per period.
- R3: While a channel's load bit is 1 (A: control bit 13, B: control bit 21), its counter is held equal to its count buffer and does not count. Its working compare takes the compare buffer value, readable at 0x14 for A and 0x18 for B.
- R4: While a channel's run bit (A: control bit 12, B: control bit 20) is 0, its counter holds its value.
- R5: Each interrupt is high for exactly one clock. The event sets a status bit at 0x1C (bit 0 for A, bit 1 for B). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: With repeat mode off (A: control bit 15, B: control bit 22), the channel fires once. The counter then stays at zero and the hardware clears the run bit.
- R7: Writing a count buffer while the channel runs does not disturb the running count. The new value takes effect at the next reload.
- R8: Channel B's live count reads at 0x40 and drops by one every two clocks. Loaded with all ones in repeat mode, the bitwise inverse of the value read rises by one per tick.
- R9: Buffers read back the last value written (A count 0x04, A compare 0x08, B count 0x0C, B compare 0x10). The control register reads back bits 12, 13, 15, 20, 21 and 22, and every other bit reads 0.
- R10: The two channels run independently, each with its own period while both are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data for bus_addr |
| irq_a | output | 1 | Channel A expiry pulse |
| irq_b | output | 1 | Channel B expiry pulse |

## Verification
A register write takes effect at the rising edge that ends its cycle. Read data is combinational, so the bench samples it just after the following falling edge. An interrupt is a function of registered state and is observed at falling edges. Periods are therefore measured as the number of rising edges between two observed pulses, which makes them independent of the prescaler phase. Decrement checks read channel B a fixed ten clocks apart, a span that always holds exactly five ticks.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq_a,
  output logic         irq_b
);
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h1C;
  localparam logic [7:0] OFF_BCNT = 8'h40;

  logic         half;
  logic         run  [2];
  logic         upd  [2];
  logic         arl  [2];
  logic         stat [2];
  logic         fire [2];
  logic [W-1:0] cnt  [2];
  logic [W-1:0] cbuf [2];
  logic [W-1:0] mbuf [2];
  logic [W-1:0] cmp  [2];

  wire wr_ctrl = bus_wr && bus_addr == OFF_CTRL;
  wire wr_stat = bus_wr && bus_addr == OFF_STAT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) half <= 1'b0;
    else        half <= ~half;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int  B_RUN = (ch == 0) ? 12 : 20;
    localparam int  B_UPD = B_RUN + 1;
    localparam int  B_ARL = (ch == 0) ? 15 : 22;
    localparam logic [7:0] OFF_CB = 8'h04 + 8'(8 * ch);
    localparam logic [7:0] OFF_MB = 8'h08 + 8'(8 * ch);

    assign fire[ch] = half && run[ch] && !upd[ch] && cnt[ch] == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run[ch] <= 1'b0;
        upd[ch] <= 1'b0;
        arl[ch] <= 1'b0;
      end else if (wr_ctrl) begin
        run[ch] <= bus_wdata[B_RUN];
        upd[ch] <= bus_wdata[B_UPD];
        arl[ch] <= bus_wdata[B_ARL];
      end else if (fire[ch] && !arl[ch]) begin
        run[ch] <= 1'b0;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cbuf[ch] <= '0;
        mbuf[ch] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == OFF_CB) cbuf[ch] <= bus_wdata;
        if (bus_addr == OFF_MB) mbuf[ch] <= bus_wdata;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[ch] <= '0;
        cmp[ch] <= '0;
      end else if (upd[ch]) begin
        cnt[ch] <= cbuf[ch];
        cmp[ch] <= mbuf[ch];
      end else if (half && run[ch]) begin
        if (cnt[ch] != '0)  cnt[ch] <= cnt[ch] - 1'b1;
        else if (arl[ch])   cnt[ch] <= cbuf[ch];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        stat[ch] <= 1'b0;
      else if (fire[ch]) stat[ch] <= 1'b1;
      else if (wr_stat && bus_wdata[ch]) stat[ch] <= 1'b0;

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire[ch] |=> !fire[ch]);
    assert_stat_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire[ch] |=> stat[ch]);
    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[ch] && arl[ch]) |=> cnt[ch] == $past(cbuf[ch]));
    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[ch] && !arl[ch] && !wr_ctrl) |=> (!run[ch] && cnt[ch] == '0));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[ch] && !upd[ch]) |=> cnt[ch] == $past(cnt[ch]));
    assert_manual_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd[ch] |=> (cnt[ch] == $past(cbuf[ch]) && cmp[ch] == $past(mbuf[ch])));
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (half && run[ch] && !upd[ch] && cnt[ch] != '0) |=> cnt[ch] == $past(cnt[ch]) - 1'b1);
  end

  assign irq_a = fire[0];
  assign irq_b = fire[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL: begin
        bus_rdata[12] = run[0];
        bus_rdata[13] = upd[0];
        bus_rdata[15] = arl[0];
        bus_rdata[20] = run[1];
        bus_rdata[21] = upd[1];
        bus_rdata[22] = arl[1];
      end
      8'h04:    bus_rdata = cbuf[0];
      8'h08:    bus_rdata = mbuf[0];
      8'h0C:    bus_rdata = cbuf[1];
      8'h10:    bus_rdata = mbuf[1];
      8'h14:    bus_rdata = cmp[0];
      8'h18:    bus_rdata = cmp[1];
      OFF_STAT: bus_rdata[1:0] = {stat[1], stat[0]};
      OFF_BCNT: bus_rdata = cnt[1];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/dual_down_timer_tb.sv
`timescale 1ns/1ps
module dual_down_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq_a, irq_b;
  int checks = 0, fails = 0, cyc = 0;

  dual_down_timer #(.W(32)) u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, output int t);
    t = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if ((ch == 0) ? irq_a : irq_b) begin t = cyc; return; end
    end
  endtask

  task automatic measure(input int ch, input int expp, input string req);
    int t1, t2;
    wait_irq(ch, t1);
    @(negedge clk);
    chk(((ch == 0) ? irq_a : irq_b) == 1'b0, "R5", "pulse width", 1, 0);
    wait_irq(ch, t2);
    chk(t1 >= 0 && t2 > t1 && t2 - t1 == expp, req, "period", t2 - t1, expp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, v2;
    int t1, t2, t3, n_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a <= 8'h40; a += 4) begin
      rd(8'(a), v);
      chk(v == 0, "R1", "reset readback", v, 0);
    end
    chk(!irq_a && !irq_b, "R1", "irq low", {irq_a, irq_b}, 0);

    // R9: buffer and control readback
    wr(8'h04, 32'h1234_5678); wr(8'h08, 32'h0000_0055);
    wr(8'h0C, 32'hCAFE_0001); wr(8'h10, 32'h0000_00AA);
    rd(8'h04, v); chk(v == 32'h1234_5678, "R9", "A count buf", v, 32'h1234_5678);
    rd(8'h08, v); chk(v == 32'h55, "R9", "A cmp buf", v, 32'h55);
    rd(8'h0C, v); chk(v == 32'hCAFE_0001, "R9", "B count buf", v, 32'hCAFE_0001);
    rd(8'h10, v); chk(v == 32'hAA, "R9", "B cmp buf", v, 32'hAA);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 32'h0070_B000, "R9", "ctrl readback", v, 32'h0070_B000);

    // R3: load bits hold counter at buffer and copy compare
    wr(8'h0C, 32'd77);
    wr(8'h00, 32'h0020_2000);
    repeat (10) @(negedge clk);
    rd(8'h40, v); chk(v == 77, "R3", "B held at buffer", v, 77);
    rd(8'h14, v); chk(v == 32'h55, "R3", "A working compare", v, 32'h55);
    rd(8'h18, v); chk(v == 32'hAA, "R3", "B working compare", v, 32'hAA);

    // R2 and R10: period sweep with both channels running
    for (int n = 0; n < 8; n++) begin
      wr(8'h04, 32'(n)); wr(8'h0C, 32'(n + 3));
      wr(8'h00, 32'h0020_2000);
      wr(8'h00, 32'h0050_9000);
      measure(0, 2 * (n + 1), "R2");
      measure(1, 2 * (n + 4), "R10");
    end

    // R5: status sticky, write-1-to-clear
    wr(8'h00, 32'h0);
    rd(8'h1C, v); chk(v == 3, "R5", "status set", v, 3);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk(v == 3, "R5", "write 0 no effect", v, 3);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); chk(v == 2, "R5", "clear A", v, 2);
    wr(8'h1C, 32'h2);
    rd(8'h1C, v); chk(v == 0, "R5", "clear B", v, 0);

    // R8 and R4: B decrements and holds when stopped
    wr(8'h0C, 32'd1000);
    wr(8'h00, 32'h0020_0000);
    wr(8'h00, 32'h0050_0000);
    rd(8'h40, v1); repeat (10) @(negedge clk); rd(8'h40, v2);
    chk(v1 - v2 == 5, "R8", "five ticks per ten clocks", v1 - v2, 5);
    // R7: buffer write during run leaves the count alone
    rd(8'h40, v1);
    wr(8'h0C, 32'd5);
    repeat (8) @(negedge clk);
    rd(8'h40, v2);
    chk(v1 - v2 == 5, "R7", "count undisturbed by buffer write", v1 - v2, 5);
    wr(8'h00, 32'h0040_0000);
    rd(8'h40, v1); repeat (10) @(negedge clk); rd(8'h40, v2);
    chk(v1 == v2, "R4", "stopped count holds", v2, v1);

    // R8: free-running all-ones source
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0020_0000);
    wr(8'h00, 32'h0050_0000);
    rd(8'h40, v1); repeat (40) @(negedge clk); rd(8'h40, v2);
    chk((~v2) - (~v1) == 20, "R8", "inverse up-count", (~v2) - (~v1), 20);

    // R7: new buffer used only at next reload
    wr(8'h04, 32'd20);
    wr(8'h00, 32'h0000_2000);
    wr(8'h00, 32'h0000_9000);
    wait_irq(0, t1);
    wr(8'h04, 32'd3);
    wait_irq(0, t2);
    wait_irq(0, t3);
    chk(t2 - t1 == 42, "R7", "old period kept", t2 - t1, 42);
    chk(t3 - t2 == 8, "R7", "new period after reload", t3 - t2, 8);

    // R6: single mode on A
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h0000_2000);
    wr(8'h00, 32'h0000_1000);
    wait_irq(0, t1);
    chk(t1 >= 0, "R6", "A single fire", t1, 1);
    n_irq = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (irq_a) n_irq++; end
    chk(n_irq == 0, "R6", "A no refire", n_irq, 0);
    rd(8'h00, v); chk(v[12] == 1'b0, "R6", "A run cleared", v[12], 0);

    // R6: single mode on B
    wr(8'h0C, 32'd4);
    wr(8'h00, 32'h0020_0000);
    wr(8'h00, 32'h0010_0000);
    wait_irq(1, t1);
    chk(t1 >= 0, "R6", "B single fire", t1, 1);
    repeat (20) @(negedge clk);
    rd(8'h40, v); chk(v == 0, "R6", "B stays at zero", v, 0);
    rd(8'h00, v); chk(v[20] == 1'b0, "R6", "B run cleared", v[20], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule